// File: doc/BRIEF.md
# Gap-Free Event Buffer Writer

This block sits between a serial front-end link and a buffer memory. It turns a stream of data words into write cycles on a single memory write port. Some words arrive flagged as null, carrying nothing worth keeping. A null word is still written at the current address, but the address does not move. The next useful word lands on the same location. Each beam spill therefore leaves its stored words in one unbroken block that starts at address zero. A host can read that block in one burst, using the fill level as its length.

The block follows the spill window through start and end markers. It counts the event-boundary markers it sees inside the window. On request it runs a fast clear, stepping through every address and writing zero while it reports that it is busy. Data is taken only inside a spill. Writing stops when the last address holds a useful word.

Top module: `nsw_event_writer`

## Requirements
- R1: While synchronous reset is high, at the following clock edge all outputs go to zero: no write strobe, address 0, data 0, fill level 0, full 0, event count 0, clear busy 0.
- R2: A valid, non-null word accepted at a clock edge is written at address equal to the fill level. The write strobe is high in the cycle after that edge, and the fill level rises by one.
- R3: A valid null word accepted at a clock edge is written at the current fill-level address, and the fill level is unchanged. The next useful word overwrites it, so the useful words of a spill occupy addresses 0 up to fill level minus 1 with no gaps.
- R4: Data words presented outside a spill (before the first start marker, or after an end marker) produce no write.
- R5: A spill start marker sets the fill level and the event count to 0. A data word or event marker in that same cycle is ignored. Start has priority over end in the same cycle.
- R6: An event marker inside a spill increments the event count. The count saturates at its all-ones value.
- R7: Event markers outside a spill leave the event count frozen at its last value.
- R8: A clear request while not busy writes zero at every address 0, 1, …, DEPTH-1 on consecutive cycles, starting in the cycle after the request. Clear busy is high for the first DEPTH-1 of those cycles. The request also sets the fill level to 0.
- R9: Clear has priority. Data words, event markers and further clear requests in the request cycle and while clear busy is high are ignored, and the fill level stays 0.
- R10: Full is high exactly when the fill level equals DEPTH. While full, no data word, null or not, is written, until a spill start or a clear.
- R11: The fill level output gives the number of useful words stored in the current spill. It is the length of the block a host reads from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A data word is present this cycle |
| word_null | input | 1 | The present word carries no useful data |
| word_data | input | DW | Data word from the link |
| event_mark | input | 1 | Event boundary marker |
| spill_begin | input | 1 | Spill start marker |
| spill_stop | input | 1 | Spill end marker |
| wipe_req | input | 1 | Fast clear request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| fill_level | output | AW+1 | Useful words stored, the read-side length |
| full | output | 1 | Last address holds a useful word |
| evt_count | output | CW | Events counted in the current spill |
| wipe_busy | output | 1 | Fast clear in progress |

## Verification
The bench builds the block with an 8-bit word, AW = 3 (eight addresses) and CW = 3. With these values the full condition can be reached after eight useful words. The event counter reaches saturation at seven markers. A whole clear sweep fits in a handful of cycles, so a clear can follow a full buffer, with traffic injected throughout the sweep. A mirror of the memory, built from the observed write port, shows that null words leave no gaps and that the clear leaves every location zero.

// File: rtl/nsw_pkg.sv
package nsw_pkg;

  // Source selected for the registered memory write port
  typedef enum logic [1:0] {
    WSRC_IDLE = 2'd0,
    WSRC_WIPE = 2'd1,
    WSRC_DATA = 2'd2
  } wsrc_e;

endpackage

// File: rtl/nsw_fill_ctrl.sv
module nsw_fill_ctrl #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        restart,
  input  logic        advance,
  output logic [AW:0] level,
  output logic        full
);

  localparam int          DEPTH    = 1 << AW;
  localparam logic [AW:0] FULL_LVL = (AW + 1)'(DEPTH);

  // Pointer to the next free location; moves only for useful words
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      level <= '0;
    end else if (advance) begin
      level <= level + 1'b1;
    end
  end

  assign full = (level == FULL_LVL);

endmodule

// File: rtl/nsw_wipe_seq.sv
module nsw_wipe_seq #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = '1;

  // Address 0 is written in the start cycle, so the walk resumes at 1
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (start) begin
      busy <= 1'b1;
      addr <= AW'(1);
    end else if (busy) begin
      addr <= addr + 1'b1;
      if (addr == LAST) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nsw_evt_ctr.sv
module nsw_evt_ctr #(
  parameter int CW       = 12,
  parameter bit SATURATE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] TOP = '1;

  logic bump;

  generate
    if (SATURATE) begin : g_sat
      assign bump = tick & (count != TOP);
    end else begin : g_wrap
      assign bump = tick;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count <= '0;
    end else if (bump) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/nsw_event_writer.sv
module nsw_event_writer
  import nsw_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 4,
  parameter int CW       = 12,
  parameter bit SATURATE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_valid,
  input  logic          word_null,
  input  logic [DW-1:0] word_data,
  input  logic          event_mark,
  input  logic          spill_begin,
  input  logic          spill_stop,
  input  logic          wipe_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW:0]   fill_level,
  output logic          full,
  output logic [CW-1:0] evt_count,
  output logic          wipe_busy
);

  logic          in_spill;
  logic          busy_q;
  logic [AW-1:0] wipe_addr;
  logic          wipe_start;
  logic          open_q;
  logic          take;
  logic [AW:0]   level_q;
  logic          full_q;
  wsrc_e         wsrc;
  logic [AW-1:0] wipe_wa;

  // Spill window; a start marker wins over an end marker
  always_ff @(posedge clk) begin
    if (rst) begin
      in_spill <= 1'b0;
    end else if (spill_begin) begin
      in_spill <= 1'b1;
    end else if (spill_stop) begin
      in_spill <= 1'b0;
    end
  end

  assign wipe_start = wipe_req & ~busy_q;
  assign open_q     = in_spill & ~spill_begin & ~busy_q & ~wipe_start;
  assign take       = open_q & word_valid & ~full_q;

  nsw_wipe_seq #(.AW(AW)) u_wipe (
    .clk   (clk),
    .rst   (rst),
    .start (wipe_start),
    .busy  (busy_q),
    .addr  (wipe_addr)
  );

  nsw_fill_ctrl #(.AW(AW)) u_fill (
    .clk     (clk),
    .rst     (rst),
    .restart (spill_begin | wipe_start),
    .advance (take & ~word_null),
    .level   (level_q),
    .full    (full_q)
  );

  nsw_evt_ctr #(.CW(CW), .SATURATE(SATURATE)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .restart (spill_begin),
    .tick    (open_q & event_mark),
    .count   (evt_count)
  );

  always_comb begin
    if (wipe_start || busy_q) begin
      wsrc = WSRC_WIPE;
    end else if (take) begin
      wsrc = WSRC_DATA;
    end else begin
      wsrc = WSRC_IDLE;
    end
  end

  assign wipe_wa = wipe_start ? '0 : wipe_addr;

  // Registered write port; address and data hold between writes
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      unique case (wsrc)
        WSRC_WIPE: begin
          mem_we    <= 1'b1;
          mem_addr  <= wipe_wa;
          mem_wdata <= '0;
        end
        WSRC_DATA: begin
          mem_we    <= 1'b1;
          mem_addr  <= level_q[AW-1:0];
          mem_wdata <= word_data;
        end
        default: begin
          mem_we <= 1'b0;
        end
      endcase
    end
  end

  assign fill_level = level_q;
  assign full       = full_q;
  assign wipe_busy  = busy_q;

endmodule

// File: rtl/nsw_event_writer_chk.sv
module nsw_event_writer_chk #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          spill_begin,
  input logic          wipe_req,
  input logic          event_mark,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [AW:0]   fill_level,
  input logic          full,
  input logic [CW-1:0] evt_count,
  input logic          wipe_busy
);

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!spill_begin && !wipe_req) |=>
      (fill_level == $past(fill_level) || fill_level == $past(fill_level) + 1'b1));

  // R5
  spill_restart_chk: assert property (@(posedge clk) disable iff (rst)
    spill_begin |=> (fill_level == '0 && evt_count == '0));

  // R6
  evt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !spill_begin |=>
      (evt_count == $past(evt_count) || evt_count == $past(evt_count) + 1'b1));

  // R7
  evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!spill_begin && !event_mark) |=> (evt_count == $past(evt_count)));

  // R8
  wipe_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wipe_busy |=> (mem_we && mem_wdata == '0));

  // R8
  wipe_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wipe_busy) |-> (mem_we && mem_addr == '0 && fill_level == '0));

  // R9
  wipe_level_chk: assert property (@(posedge clk) disable iff (rst)
    wipe_busy |=> (fill_level == '0));

  // R10
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    full |=> (!mem_we || wipe_busy));

endmodule

bind nsw_event_writer nsw_event_writer_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .spill_begin (spill_begin),
  .wipe_req    (wipe_req),
  .event_mark  (event_mark),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .fill_level  (fill_level),
  .full        (full),
  .evt_count   (evt_count),
  .wipe_busy   (wipe_busy)
);

// File: tb/test_nsw_event_writer.sv
module test_nsw_event_writer;

  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int CW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          word_valid = 1'b0;
  logic          word_null = 1'b0;
  logic [DW-1:0] word_data = '0;
  logic          event_mark = 1'b0;
  logic          spill_begin = 1'b0;
  logic          spill_stop = 1'b0;
  logic          wipe_req = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [AW:0]   fill_level;
  logic          full;
  logic [CW-1:0] evt_count;
  logic          wipe_busy;

  int n_tests = 0;
  int n_fail  = 0;
  int n_cyc   = 0;

  // Behavioural reference state
  int m_lvl = 0, m_cnt = 0, m_caddr = 0;
  bit m_spill = 0, m_busy = 0;
  bit e_we = 0;
  int e_addr = 0, e_wd = 0;
  logic [DW-1:0] mirror [DEPTH];

  always #2.5 clk = ~clk;

  nsw_event_writer #(.DW(DW), .AW(AW), .CW(CW)) i_nsw_event_writer (
    .clk (clk), .rst (rst),
    .word_valid (word_valid), .word_null (word_null), .word_data (word_data),
    .event_mark (event_mark), .spill_begin (spill_begin), .spill_stop (spill_stop),
    .wipe_req (wipe_req),
    .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .fill_level (fill_level), .full (full), .evt_count (evt_count),
    .wipe_busy (wipe_busy)
  );

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit ws, acc;
    n_cyc++;
    if (rst) begin
      m_lvl = 0; m_cnt = 0; m_spill = 0; m_busy = 0; m_caddr = 0;
      e_we = 0; e_addr = 0; e_wd = 0;
    end else begin
      e_we = 0;
      ws  = wipe_req && !m_busy;
      acc = m_spill && !spill_begin && !m_busy && !ws;
      if (ws) begin
        e_we = 1; e_addr = 0; e_wd = 0; m_busy = 1; m_caddr = 1; m_lvl = 0;
      end else if (m_busy) begin
        e_we = 1; e_addr = m_caddr; e_wd = 0;
        if (m_caddr == DEPTH - 1) m_busy = 0;
        m_caddr = (m_caddr + 1) % DEPTH;
      end else if (acc && word_valid && m_lvl < DEPTH) begin
        e_we = 1; e_addr = m_lvl; e_wd = int'(word_data);
        if (!word_null) m_lvl++;
      end
      if (acc && event_mark && m_cnt < CMAX) m_cnt++;
      if (spill_begin) begin
        m_spill = 1; m_lvl = 0; m_cnt = 0;
      end else if (spill_stop) begin
        m_spill = 0;
      end
    end
    if (n_cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog R1: actual %0d cycles expected at most 20000", n_cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (n_cyc > 0) begin
      check("R2", "mem_we", int'(mem_we), int'(e_we));
      if (e_we) begin
        check("R3", "mem_addr", int'(mem_addr), e_addr);
        check("R2", "mem_wdata", int'(mem_wdata), e_wd);
      end
      check("R11", "fill_level", int'(fill_level), m_lvl);
      check("R10", "full", int'(full), int'(m_lvl == DEPTH));
      check("R6", "evt_count", int'(evt_count), m_cnt);
      check("R8", "wipe_busy", int'(wipe_busy), int'(m_busy));
      if (mem_we) mirror[mem_addr] = mem_wdata;
    end
  end

  task automatic drive(bit v, bit n, logic [DW-1:0] d, bit ev, bit sb, bit ss, bit wr);
    word_valid = v; word_null = n; word_data = d; event_mark = ev;
    spill_begin = sb; spill_stop = ss; wipe_req = wr;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(0, 0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mirror[i] = 8'hFF;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "mem_we", int'(mem_we), 0);
    check("R1", "mem_addr", int'(mem_addr), 0);
    check("R1", "mem_wdata", int'(mem_wdata), 0);
    check("R1", "fill_level", int'(fill_level), 0);
    check("R1", "full", int'(full), 0);
    check("R1", "evt_count", int'(evt_count), 0);
    check("R1", "wipe_busy", int'(wipe_busy), 0);
    rst = 1'b0;

    // R4 / R7: traffic before any spill
    drive(1, 0, 8'h11, 1, 0, 0, 0);
    check("R4", "no write outside spill", int'(mem_we), 0);
    drive(1, 0, 8'h12, 1, 0, 0, 0);
    check("R7", "count before spill", int'(evt_count), 0);

    // R5: start marker with a word in the same cycle
    drive(1, 0, 8'h22, 1, 1, 0, 0);
    check("R5", "word at start ignored", int'(mem_we), 0);
    check("R5", "level at start", int'(fill_level), 0);

    // R2 / R3: useful and null words mixed
    drive(1, 0, 8'hA1, 0, 0, 0, 0);
    check("R2", "first addr", int'(mem_addr), 0);
    check("R2", "level after first", int'(fill_level), 1);
    drive(1, 1, 8'hEE, 0, 0, 0, 0);
    check("R3", "null addr", int'(mem_addr), 1);
    check("R3", "level after null", int'(fill_level), 1);
    drive(1, 0, 8'hC3, 0, 0, 0, 0);
    check("R3", "overwrite addr", int'(mem_addr), 1);
    drive(1, 1, 8'hEF, 0, 0, 0, 0);
    drive(1, 1, 8'hED, 0, 0, 0, 0);
    drive(1, 0, 8'hD4, 1, 0, 0, 0);
    idle();
    check("R3", "mirror[0]", int'(mirror[0]), 'hA1);
    check("R3", "mirror[1]", int'(mirror[1]), 'hC3);
    check("R3", "mirror[2]", int'(mirror[2]), 'hD4);
    check("R11", "block length", int'(fill_level), 3);
    check("R6", "one event", int'(evt_count), 1);

    // R6: saturation
    for (int i = 0; i < 9; i++) drive(0, 0, '0, 1, 0, 0, 0);
    check("R6", "saturated count", int'(evt_count), CMAX);

    // R7 / R4: after end marker
    drive(0, 0, '0, 0, 0, 1, 0);
    drive(1, 0, 8'h77, 1, 0, 0, 0);
    check("R4", "no write after end", int'(mem_we), 0);
    check("R7", "frozen count", int'(evt_count), CMAX);
    check("R4", "level kept", int'(fill_level), 3);

    // R5: new spill, start wins over end in the same cycle
    drive(0, 0, '0, 0, 1, 1, 0);
    check("R5", "count cleared", int'(evt_count), 0);
    check("R5", "level cleared", int'(fill_level), 0);

    // R10: fill to the last address
    for (int i = 0; i < DEPTH; i++) drive(1, 0, DW'(8'h30 + i), 0, 0, 0, 0);
    check("R10", "full set", int'(full), 1);
    check("R10", "level at full", int'(fill_level), DEPTH);
    drive(1, 0, 8'h99, 0, 0, 0, 0);
    check("R10", "useful word blocked", int'(mem_we), 0);
    drive(1, 1, 8'h98, 0, 0, 0, 0);
    check("R10", "null word blocked", int'(mem_we), 0);
    for (int i = 0; i < DEPTH; i++) check("R10", "stored word", int'(mirror[i]), 'h30 + i);

    // R8 / R9: fast clear with traffic during the sweep
    drive(1, 0, 8'h44, 1, 0, 0, 1);
    check("R8", "busy after request", int'(wipe_busy), 1);
    check("R8", "first clear addr", int'(mem_addr), 0);
    check("R8", "level after request", int'(fill_level), 0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      drive(1, 0, 8'h55, 1, 0, 0, 1);
      check("R9", "level during clear", int'(fill_level), 0);
      check("R9", "count during clear", int'(evt_count), 0);
    end
    check("R8", "busy done", int'(wipe_busy), 0);
    idle();
    for (int i = 0; i < DEPTH; i++) check("R8", "cleared word", int'(mirror[i]), 0);

    // R2: writing resumes at address 0
    drive(1, 0, 8'h5A, 0, 0, 0, 0);
    check("R2", "addr after clear", int'(mem_addr), 0);
    check("R2", "data after clear", int'(mem_wdata), 'h5A);
    check("R2", "level after clear", int'(fill_level), 1);
    idle();
    idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule